// File: doc/BRIEF.md
# Integer ALU with Barrel Shifter

This block is the pure-combinational execute unit of a 32-bit load-store RISC datapath. It takes two operands, a separate 5-bit shift distance and a 4-bit operation code. In the same cycle it returns a 32-bit result and a flag that is high when the result is all zeros. The branch logic uses that flag for its equal and not-equal tests.

The operations are:
- wrapping add and subtract;
- the bitwise set AND, OR and NOR (NOR with a zero operand inverts);
- a signed set-less-than that gives 0 or 1;
- three shifts: left logical, right logical and right arithmetic;
- an upper-half placement that loads a 16-bit constant into the top of the word.

The block has no state, so it has no states or transitions. The upstream decode logic has already sign- or zero-extended any immediate. That logic drives the operation code directly.

Top module: `alu_core`

## Requirements
- R1: Code 0 (add) gives `a + b` modulo 2^32, with no trap or flag on signed overflow.
- R2: Code 1 (subtract) gives `a - b` in two's complement modulo 2^32.
- R3: Code 2 gives the bitwise AND of `a` and `b`.
- R4: Code 3 gives the bitwise OR of `a` and `b`.
- R5: Code 4 gives the bitwise NOR of `a` and `b`; with `b` = 0 this is the inversion of `a`.
- R6: Code 5 gives 32'd1 when `a` is less than `b` as signed numbers and 32'd0 otherwise. This holds when `a - b` overflows, and it gives 0 when the operands are equal.
- R7: Code 6 shifts `a` left by `shamt` places and fills with zeros. A distance of 0 returns `a` unchanged.
- R8: Code 7 shifts `a` right by `shamt` places and fills with zeros.
- R9: Code 8 shifts `a` right by `shamt` places and fills with copies of `a[31]`, so the sign is kept.
- R10: Code 9 gives `{b[15:0], 16'h0000}`; `a` and `b[31:16]` have no effect.
- R11: `zero` is 1 exactly when `result` is 32'h0, for every operation.
- R12: Codes 10 to 15 give a result of 0 with `zero` = 1.
- R13: `shamt` has no effect on the non-shift operations (codes 0 to 5 and 9).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a | input | 32 | First operand; the value shifted by shift operations |
| b | input | 32 | Second operand; its low half is the constant for upper placement |
| shamt | input | 5 | Shift distance |
| op | input | 4 | Operation code (0 to 9 used) |
| result | output | 32 | Operation result |
| zero | output | 1 | High when result is all zeros |

## Verification
Add and subtract are tried with small values, with carry-out wrap and with signed overflow at the boundary between the most positive and most negative values. These cases separate true modulo arithmetic from saturating or trapping behaviour. Set-less-than is driven with equal operands, with mixed-sign operands and with the two operand pairs whose difference overflows. These cases separate a plain sign-of-difference comparison from the overflow-corrected one. The shifts use distances 0, 1, 4 and 31 on operands with the top bit set and with it clear, which separates zero fill from sign fill. Upper placement and the non-shift operations carry junk in the inputs that they ignore, so any leak of those inputs shows in the result.

// File: rtl/alu_pkg.sv
package alu_pkg;

    localparam int OP_W = 4;

    typedef enum logic [OP_W-1:0] {
        OP_ADD  = 4'd0,
        OP_SUB  = 4'd1,
        OP_AND  = 4'd2,
        OP_OR   = 4'd3,
        OP_NOR  = 4'd4,
        OP_SLT  = 4'd5,
        OP_SHL  = 4'd6,
        OP_SHRL = 4'd7,
        OP_SHRA = 4'd8,
        OP_UPH  = 4'd9
    } alu_op_e;

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             sub,
    output logic [WIDTH-1:0] sum,
    output logic             lt
);

    logic [WIDTH-1:0] b_eff;
    logic             ovf;

    always_comb begin
        b_eff = sub ? ~b : b;
        sum   = a + b_eff + {{(WIDTH-1){1'b0}}, sub};
        ovf   = (a[WIDTH-1] == b_eff[WIDTH-1]) && (sum[WIDTH-1] != a[WIDTH-1]);
        lt    = sum[WIDTH-1] ^ ovf;
    end

    always_comb begin
        // R6
        equal_not_less_chk: assert (!(sub && (a == b)) || (!lt && (sum == '0)));
        // R1
        add_identity_chk: assert (sub || (b != '0) || (sum == a));
    end

endmodule

// File: rtl/alu_logic.sv
module alu_logic #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    output logic [WIDTH-1:0] and_o,
    output logic [WIDTH-1:0] or_o,
    output logic [WIDTH-1:0] nor_o
);

    always_comb begin
        and_o = a & b;
        or_o  = a | b;
        nor_o = ~(a | b);
    end

    always_comb begin
        // R3
        and_within_or_chk: assert ((and_o & ~or_o) == '0);
        // R5
        nor_disjoint_chk: assert ((nor_o & a) == '0);
    end

endmodule

// File: rtl/alu_lshift.sv
module alu_lshift #(
    parameter int WIDTH = 32,
    parameter int SHW   = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] a,
    input  logic [SHW-1:0]   shamt,
    output logic [WIDTH-1:0] y
);

    logic [WIDTH-1:0] stg [SHW+1];

    assign stg[0] = a;

    for (genvar k = 0; k < SHW; k++) begin : g_stage
        localparam int D = 2 ** k;
        assign stg[k+1] = shamt[k] ? {stg[k][WIDTH-1-D:0], {D{1'b0}}} : stg[k];
    end

    assign y = stg[SHW];

    always_comb begin
        // R7
        lsh_zero_dist_chk: assert ((shamt != '0) || (y == a));
        // R7
        lsh_low_fill_chk: assert ((shamt == '0) || (y[0] == 1'b0));
    end

endmodule

// File: rtl/alu_rshift.sv
module alu_rshift #(
    parameter int WIDTH = 32,
    parameter int SHW   = $clog2(WIDTH),
    parameter bit ARITH = 1'b0
) (
    input  logic [WIDTH-1:0] a,
    input  logic [SHW-1:0]   shamt,
    output logic [WIDTH-1:0] y
);

    logic             fill;
    logic [WIDTH-1:0] stg [SHW+1];

    if (ARITH) begin : g_sign_fill
        assign fill = a[WIDTH-1];
    end else begin : g_zero_fill
        assign fill = 1'b0;
    end

    assign stg[0] = a;

    for (genvar k = 0; k < SHW; k++) begin : g_stage
        localparam int D = 2 ** k;
        assign stg[k+1] = shamt[k] ? {{D{fill}}, stg[k][WIDTH-1:D]} : stg[k];
    end

    assign y = stg[SHW];

    always_comb begin
        // R9
        rsh_sign_keep_chk: assert (!ARITH || (y[WIDTH-1] == a[WIDTH-1]));
        // R8
        rsh_top_fill_chk: assert (ARITH || (shamt == '0) || (y[WIDTH-1] == 1'b0));
    end

endmodule

// File: rtl/alu_core.sv
module alu_core
    import alu_pkg::*;
#(
    parameter int WIDTH = 32,
    parameter int SHW   = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic [SHW-1:0]   shamt,
    input  logic [OP_W-1:0]  op,
    output logic [WIDTH-1:0] result,
    output logic             zero
);

    localparam int HALF = WIDTH / 2;

    logic             do_sub;
    logic [WIDTH-1:0] sum_w, and_w, or_w, nor_w, shl_w, shrl_w, shra_w;
    logic             lt_w;

    assign do_sub = (op == OP_SUB) || (op == OP_SLT);

    alu_addsub #(.WIDTH(WIDTH)) u_addsub (
        .a(a), .b(b), .sub(do_sub), .sum(sum_w), .lt(lt_w)
    );

    alu_logic #(.WIDTH(WIDTH)) u_logic (
        .a(a), .b(b), .and_o(and_w), .or_o(or_w), .nor_o(nor_w)
    );

    alu_lshift #(.WIDTH(WIDTH), .SHW(SHW)) u_shl (
        .a(a), .shamt(shamt), .y(shl_w)
    );

    alu_rshift #(.WIDTH(WIDTH), .SHW(SHW), .ARITH(1'b0)) u_shrl (
        .a(a), .shamt(shamt), .y(shrl_w)
    );

    alu_rshift #(.WIDTH(WIDTH), .SHW(SHW), .ARITH(1'b1)) u_shra (
        .a(a), .shamt(shamt), .y(shra_w)
    );

    always_comb begin
        case (op)
            OP_ADD, OP_SUB: result = sum_w;
            OP_AND:         result = and_w;
            OP_OR:          result = or_w;
            OP_NOR:         result = nor_w;
            OP_SLT:         result = {{(WIDTH-1){1'b0}}, lt_w};
            OP_SHL:         result = shl_w;
            OP_SHRL:        result = shrl_w;
            OP_SHRA:        result = shra_w;
            OP_UPH:         result = {b[HALF-1:0], {HALF{1'b0}}};
            default:        result = '0;
        endcase
        zero = (result == '0);
    end

    always_comb begin
        // R10
        uph_low_clear_chk: assert ((op != OP_UPH) || (result[HALF-1:0] == '0));
        // R6
        slt_bool_chk: assert ((op != OP_SLT) || (result[WIDTH-1:1] == '0));
        // R12
        spare_code_chk: assert ((op < 4'd10) || zero);
    end

endmodule

// File: tb/alu_core_test.sv
module alu_core_test;

    localparam int CLK_PERIOD = 10;
    localparam int WD_CYCLES  = 20000;
    localparam int NV         = 30;

    // {req[3:0], op[3:0], a[31:0], b[31:0], shamt[4:0], expected[31:0]}
    localparam logic [108:0] VEC [NV] = '{
        {4'd1,  4'd0, 32'h00000005, 32'h00000003, 5'd17, 32'h00000008}, // R1
        {4'd1,  4'd0, 32'hFFFFFFFF, 32'h00000001, 5'd0,  32'h00000000}, // R1 wrap
        {4'd1,  4'd0, 32'h7FFFFFFF, 32'h00000001, 5'd9,  32'h80000000}, // R1 overflow
        {4'd2,  4'd1, 32'h00000005, 32'h00000003, 5'd31, 32'h00000002}, // R2
        {4'd2,  4'd1, 32'h00000003, 32'h00000005, 5'd0,  32'hFFFFFFFE}, // R2
        {4'd2,  4'd1, 32'h80000000, 32'h00000001, 5'd3,  32'h7FFFFFFF}, // R2
        {4'd3,  4'd2, 32'hF0F0F0F0, 32'hFF00FF00, 5'd5,  32'hF000F000}, // R3
        {4'd4,  4'd3, 32'hF0F0F0F0, 32'h0F0F0000, 5'd5,  32'hFFFFF0F0}, // R4
        {4'd5,  4'd4, 32'h12345678, 32'h00000000, 5'd1,  32'hEDCBA987}, // R5
        {4'd5,  4'd4, 32'hF0F0F0F0, 32'h0F0F0F0F, 5'd0,  32'h00000000}, // R5
        {4'd6,  4'd5, 32'h00000003, 32'h00000005, 5'd30, 32'h00000001}, // R6
        {4'd6,  4'd5, 32'h00000005, 32'h00000003, 5'd0,  32'h00000000}, // R6
        {4'd6,  4'd5, 32'hFFFFFFFF, 32'h00000001, 5'd0,  32'h00000001}, // R6
        {4'd6,  4'd5, 32'h80000000, 32'h7FFFFFFF, 5'd0,  32'h00000001}, // R6 ovf
        {4'd6,  4'd5, 32'h7FFFFFFF, 32'h80000000, 5'd0,  32'h00000000}, // R6 ovf
        {4'd6,  4'd5, 32'hDEADBEEF, 32'hDEADBEEF, 5'd0,  32'h00000000}, // R6 eq
        {4'd7,  4'd6, 32'h00000001, 32'hFFFFFFFF, 5'd31, 32'h80000000}, // R7
        {4'd7,  4'd6, 32'hC0000001, 32'h00000000, 5'd1,  32'h80000002}, // R7
        {4'd7,  4'd6, 32'hA5A5A5A5, 32'h00000000, 5'd0,  32'hA5A5A5A5}, // R7
        {4'd8,  4'd7, 32'h80000000, 32'h00000000, 5'd31, 32'h00000001}, // R8
        {4'd8,  4'd7, 32'hF0000000, 32'h00000000, 5'd4,  32'h0F000000}, // R8
        {4'd9,  4'd8, 32'h80000000, 32'h00000000, 5'd31, 32'hFFFFFFFF}, // R9
        {4'd9,  4'd8, 32'hF0000000, 32'h00000000, 5'd4,  32'hFF000000}, // R9
        {4'd9,  4'd8, 32'h70000000, 32'h00000000, 5'd4,  32'h07000000}, // R9
        {4'd9,  4'd8, 32'hFFFFFFF8, 32'h00000000, 5'd1,  32'hFFFFFFFC}, // R9
        {4'd10, 4'd9, 32'h13579BDF, 32'h0000ABCD, 5'd7,  32'hABCD0000}, // R10
        {4'd10, 4'd9, 32'hFFFFFFFF, 32'hFFFF1234, 5'd0,  32'h12340000}, // R10
        {4'd13, 4'd2, 32'hFFFFFFFF, 32'h0000FFFF, 5'd31, 32'h0000FFFF}, // R13
        {4'd13, 4'd9, 32'h00000000, 32'h00000001, 5'd16, 32'h00010000}, // R13
        {4'd13, 4'd1, 32'h00000010, 32'h00000010, 5'd8,  32'h00000000}  // R13
    };

    logic        clk;
    logic [31:0] a, b, result;
    logic [4:0]  shamt;
    logic [3:0]  op;
    logic        zero;
    int          checks = 0;
    int          errors = 0;
    int          cycles = 0;

    alu_core uut (
        .a(a), .b(b), .shamt(shamt), .op(op), .result(result), .zero(zero)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles == WD_CYCLES) begin
            errors = errors + 1;
            $display("FAIL watchdog expired after %0d cycles", cycles);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic apply(input logic [3:0] o, input logic [31:0] x,
                         input logic [31:0] y, input logic [4:0] s);
        @(negedge clk);
        op = o; a = x; b = y; shamt = s;
        #1;
    endtask

    task automatic check(input int req, input logic [31:0] exp);
        checks = checks + 1;
        if (result !== exp) begin
            errors = errors + 1;
            $display("FAIL R%0d result op=%0d a=%h b=%h sh=%0d: actual %h expected %h",
                     req, op, a, b, shamt, result, exp);
        end
        checks = checks + 1;
        if (zero !== (exp == 32'h0)) begin
            errors = errors + 1;
            $display("FAIL R11 zero flag op=%0d: actual %b expected %b",
                     op, zero, (exp == 32'h0));
        end
    endtask

    initial begin
        op = 4'd0; a = '0; b = '0; shamt = '0;
        // Idle inputs: all zeros add to zero, zero flag high (R1, R11)
        apply(4'd0, 32'h0, 32'h0, 5'd0);
        check(1, 32'h0);

        for (int i = 0; i < NV; i++) begin
            apply(VEC[i][104:101], VEC[i][100:69], VEC[i][68:37], VEC[i][36:32]);
            check(int'(VEC[i][108:105]), VEC[i][31:0]);
        end

        // R12: spare codes give zero regardless of operands
        for (int c = 10; c < 16; c++) begin
            apply(4'(c), 32'hFFFFFFFF, 32'h12345678, 5'd3);
            check(12, 32'h0);
        end

        // R5: NOR with zero inverts all-zero word
        apply(4'd4, 32'h00000000, 32'h00000000, 5'd0);
        check(5, 32'hFFFFFFFF);

        // R9: arithmetic shift of positive max by 31 gives zero
        apply(4'd8, 32'h7FFFFFFF, 32'h0, 5'd31);
        check(9, 32'h0);

        // R6: most negative vs zero
        apply(4'd5, 32'h80000000, 32'h0, 5'd0);
        check(6, 32'h1);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule